// File: doc/BRIEF.md
# Selectable Fractional System Clock Divider

This block derives an internal system clock from one of two source clocks, a master clock or a PLL clock, and scales it by one of eight ratios chosen with a 3-bit code. The ratio set is 1, 1.5, 2, 3, 4, 6, 8 and 12. The non-integer ratio of 1.5 needs half-cycle resolution, so the model counts both edges of the chosen source.

Everything runs on a single fast reference clock. Each source is presented as an edge strobe: a one-cycle pulse on the reference clock for every rising or falling edge of that source. A source period is therefore two strobes, and an output period spans an integer number of strobes: 2, 3, 4, 6, 8, 12, 16 or 24.

The source select and the divide code are sampled only at the end of an output period, so reselection never cuts a period short. The block drives two outputs. The first is a level output that follows the divided clock. The second is a one-cycle pulse marking the start of each output period, which can be used as a clock enable.

Top module: `sysclk_divider`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `sys_clk_o` and `sys_tick_o` are low and the internal edge counter is zero.
- R2: Reset loads an active configuration of source 1 (PLL) and code 010 (divide by 2). The first output period after reset therefore lasts 4 PLL edge strobes, whatever `src_sel_i` and `div_code_i` hold.
- R3: An active select of 0 counts only `mclk_edge_i` strobes and an active select of 1 counts only `pll_edge_i` strobes. Strobes on the unselected input have no effect on either output.
- R4: The active code sets the output period, measured in selected strobes, as follows: 000→2, 001→3, 010→4, 011→6, 100→8, 101→12, 110→16, 111→24.
- R5: Code 001 gives divide by 1.5: exactly 3 selected strobes per output period, which is two output periods for every three source periods.
- R6: Every output period starts with `sys_clk_o` low. The output is high for floor(N/2) strobes and low for the remaining ceil(N/2) strobes, where N is the period length in strobes. Even ratios therefore have a 50% duty cycle.
- R7: New values on `src_sel_i` and `div_code_i` are taken only at an output period boundary. A period already in progress completes with the old configuration.
- R8: `sys_tick_o` is high for exactly one reference cycle at the start of each output period. This is the cycle after the strobe that completes the previous period.
- R9: `sys_clk_o` can change only on the reference cycle after a strobe on the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_edge_i | input | 1 | Strobe for each edge of the master clock |
| pll_edge_i | input | 1 | Strobe for each edge of the PLL clock |
| src_sel_i | input | 1 | Source select: 0 master, 1 PLL |
| div_code_i | input | 3 | Divide ratio code (see R4) |
| sys_clk_o | output | 1 | Divided system clock level |
| sys_tick_o | output | 1 | One-cycle pulse at each output period start |

## Verification
Several properties are checked by assertions on every cycle. The output level moves only after a selected strobe. The active configuration changes only together with a period-start pulse. Each period starts low. The counter stays within the active period. The start pulse never lasts two cycles. The bench scenarios cover the rest: the exact period and high time for every code on both sources, the reset configuration, and the ignored unselected source. They also show that a code written mid-period takes effect one full period later. These behaviours depend on the strobe pattern and on sequences of settings, which a per-cycle property cannot express.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic              sel;
        logic [CODE_W-1:0] code;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{sel: 1'b1, code: 3'b010};

    // Output period length in source edges (two edges per source cycle)
    function automatic cnt_t period_edges(input logic [CODE_W-1:0] code);
        cnt_t n;
        case (code)
            3'b000:  n = cnt_t'(2);
            3'b001:  n = cnt_t'(3);
            3'b010:  n = cnt_t'(4);
            3'b011:  n = cnt_t'(6);
            3'b100:  n = cnt_t'(8);
            3'b101:  n = cnt_t'(12);
            3'b110:  n = cnt_t'(16);
            default: n = cnt_t'(24);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sysdiv_src_sel.sv
module sysdiv_src_sel (
    input  logic sel_i,
    input  logic mclk_edge_i,
    input  logic pll_edge_i,
    output logic edge_o
);
    always_comb begin
        edge_o = sel_i ? pll_edge_i : mclk_edge_i;
    end
endmodule

// File: rtl/sysdiv_ratio.sv
module sysdiv_ratio
    import sysdiv_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = CNT_W
) (
    input  logic [CW-1:0] code_i,
    output logic [NW-1:0] period_o,
    output logic [NW-1:0] low_len_o
);
    always_comb begin
        period_o  = NW'(period_edges(code_i));
        // low phase takes the larger half when the period is odd
        low_len_o = period_o - (period_o >> 1);
    end
endmodule

// File: rtl/sysdiv_period_ctr.sv
module sysdiv_period_ctr
    import sysdiv_pkg::*;
#(
    parameter int NW = CNT_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          edge_i,
    input  cfg_t          cfg_in_i,
    input  logic [NW-1:0] period_i,
    input  logic [NW-1:0] low_len_i,
    output cfg_t          cfg_o,
    output logic          clk_o,
    output logic          tick_o
);
    typedef struct packed {
        logic [NW-1:0] cnt;
        cfg_t          cfg;
        logic          lvl;
        logic          tick;
    } st_t;

    st_t st_d, st_q;
    logic last_edge;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        last_edge = (st_q.cnt == NW'(period_i - 1'b1));
        if (edge_i) begin
            if (last_edge) begin
                st_d.cnt  = '0;
                st_d.cfg  = cfg_in_i;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.lvl = (st_d.cnt >= low_len_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, cfg: CFG_RESET, lvl: 1'b0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign clk_o  = st_q.lvl;
    assign tick_o = st_q.tick;

    p_lvl_on_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !edge_i |=> $stable(clk_o))
        else $error("R9: output level moved without a selected edge");

    p_cfg_at_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_o != $past(cfg_o)) |-> tick_o)
        else $error("R7: configuration changed away from a period boundary");

    p_start_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> !clk_o)
        else $error("R6: period did not start low");

    p_cnt_in_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < period_i)
        else $error("R4: counter beyond active period");

    p_tick_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o)
        else $error("R8: period pulse longer than one cycle");
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
    import sysdiv_pkg::*;
#(
    parameter int NW = CNT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mclk_edge_i,
    input  logic              pll_edge_i,
    input  logic              src_sel_i,
    input  logic [CODE_W-1:0] div_code_i,
    output logic              sys_clk_o,
    output logic              sys_tick_o
);
    cfg_t          cfg_act;
    cfg_t          cfg_new;
    logic          sel_edge;
    logic [NW-1:0] period_len;
    logic [NW-1:0] low_len;

    assign cfg_new = '{sel: src_sel_i, code: div_code_i};

    sysdiv_src_sel u_src (
        .sel_i       (cfg_act.sel),
        .mclk_edge_i (mclk_edge_i),
        .pll_edge_i  (pll_edge_i),
        .edge_o      (sel_edge)
    );

    sysdiv_ratio #(.CW(CODE_W), .NW(NW)) u_ratio (
        .code_i    (cfg_act.code),
        .period_o  (period_len),
        .low_len_o (low_len)
    );

    sysdiv_period_ctr #(.NW(NW)) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .edge_i    (sel_edge),
        .cfg_in_i  (cfg_new),
        .period_i  (period_len),
        .low_len_i (low_len),
        .cfg_o     (cfg_act),
        .clk_o     (sys_clk_o),
        .tick_o    (sys_tick_o)
    );

    p_reset_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!sys_clk_o && !sys_tick_o))
        else $error("R1: outputs not low after reset");
endmodule

// File: tb/sysclk_divider_bench.sv
module sysclk_divider_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk_on = 1'b0, pll_on = 1'b0, pll_slow = 1'b0;
    logic       mclk_edge = 1'b0, pll_edge = 1'b0;
    logic       sel = 1'b0;
    logic [2:0] code = 3'b000;
    logic       sclk, stick;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    sysclk_divider u_sysclk_divider (
        .clk_i(clk), .rst_ni(rst_n), .mclk_edge_i(mclk_edge), .pll_edge_i(pll_edge),
        .src_sel_i(sel), .div_code_i(code), .sys_clk_o(sclk), .sys_tick_o(stick)
    );

    // master: an edge every cycle; PLL: every cycle or every other cycle
    always @(negedge clk) begin
        mclk_edge <= mclk_on;
        pll_edge  <= !pll_on ? 1'b0 : (pll_slow ? ~pll_edge : 1'b1);
    end

    typedef struct packed {
        logic       sel;
        logic [2:0] code;
        logic [7:0] per;
        logic [7:0] hi;
    } vec_t;

    // expected cycles per period and high cycles (master 1 edge/cycle, PLL 1 edge/2 cycles)
    localparam vec_t VECS [12] = '{
        '{1'b0, 3'b000, 8'd2,  8'd1},
        '{1'b0, 3'b001, 8'd3,  8'd1},
        '{1'b0, 3'b010, 8'd4,  8'd2},
        '{1'b0, 3'b011, 8'd6,  8'd3},
        '{1'b0, 3'b100, 8'd8,  8'd4},
        '{1'b0, 3'b101, 8'd12, 8'd6},
        '{1'b0, 3'b110, 8'd16, 8'd8},
        '{1'b0, 3'b111, 8'd24, 8'd12},
        '{1'b1, 3'b001, 8'd6,  8'd2},
        '{1'b1, 3'b111, 8'd48, 8'd24},
        '{1'b1, 3'b000, 8'd4,  8'd2},
        '{1'b0, 3'b001, 8'd3,  8'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called right after a start pulse was sampled; counts cycles to the next pulse
    task automatic measure(output int per, output int hi);
        per = 0; hi = 0;
        do begin
            @(negedge clk);
            per++;
            if (sclk && !stick) hi++;
        end while (!stick && per < 200);
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!stick && n < 200);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, per, hi, tick_seen;
        vec_t prev;
        repeat (3) @(negedge clk);
        check("R1 clk low in reset", int'(sclk), 0);
        check("R1 tick low in reset", int'(stick), 0);
        pll_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        // inputs hold master/000, but the reset configuration is PLL /2
        wait_tick(n);
        check("R2 first period from reset config", n, 4);
        // now master selected and idle; PLL strobes must be ignored
        pll_slow = 1'b1;
        tick_seen = 0;
        repeat (20) begin
            @(negedge clk);
            if (stick || sclk) tick_seen++;
        end
        check("R3 unselected source ignored", tick_seen, 0);
        mclk_on = 1'b1;
        wait_tick(n);
        prev = VECS[0];
        for (int i = 0; i < 12; i++) begin
            sel  = VECS[i].sel;
            code = VECS[i].code;
            measure(per, hi);
            check("R7 old config completes period", per, int'(prev.per));
            measure(per, hi);
            check(VECS[i].code == 3'b001 ? "R5 period of /1.5" : "R4 period", per, int'(VECS[i].per));
            check("R6 high time", hi, int'(VECS[i].hi));
            prev = VECS[i];
        end
        // R8: pulse lasts one cycle at the start of the period
        @(negedge clk);
        check("R8 pulse one cycle", int'(stick), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule